// File: doc/BRIEF.md
# Dual-FIFO Inter-Processor Mailbox

This block carries short messages between an application processor (AP) and an I/O co-processor (IOP). Each message is 96 bits wide: a 64-bit word and a 32-bit word. Two independent queues carry the traffic. The outbound queue runs only from the AP to the IOP, and the inbound queue runs only from the IOP to the AP. Both processors reach one shared register window over a simple single-cycle read/write bus. Arbitration between the two processors happens outside the block.

A sender writes the 64-bit word first, which only stages it. It then writes the 32-bit word, and that write pushes the complete message. A receiver reads the head 64-bit word, which leaves the queue unchanged. It then reads the second word, which returns the 32-bit payload with queue status in its upper bits, and that read pops the entry. Each direction has a control register with full, empty and sticky overflow flags.

A small interrupt unit latches four conditions, one empty and one not-empty condition per queue. Each latched bit stays set until it is acknowledged. The unit drives four level outputs, each gated by an enable bit.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues are empty. Each control register reads exactly bit 17 set (empty=1, full=0, overflow=0). The enable register reads 0 and `irq_lines` is 0.
- R2: A write to send word 0 (outbound 0x60, inbound 0x90) only stages data and leaves the queue unchanged. A write to send word 1 (0x68 / 0x98) pushes {staged word, wdata[31:0]}. The bits of wdata above bit 31 are ignored. Receive word 0 (0x70 / 0xA0) returns the head 64-bit word and leaves the queue unchanged. Receive word 1 (0x78 / 0xA8) returns the payload in bits 31:0 and pops the entry. Messages leave in push order, and the two directions are independent.
- R3: Control registers sit at 0x50 (outbound) and 0x80 (inbound). Bit 16 reads 1 exactly when the queue holds 16 entries, and bit 17 reads 1 exactly when it holds none.
- R4: A push to a full queue is dropped and sets control bit 18. Bit 18 stays set until a control write with bit 18 = 1 clears it.
- R5: A read of a receive word while that queue is empty returns 0 in bits 31:0 (word 1) or in all bits (word 0). It moves no pointer.
- R6: Receive word 1 reports the following fields, all sampled before that access's pop. Bits 56:52 hold the outbound occupancy (0..16). Bits 51:48 hold the inbound occupancy modulo 16. Bits 47:44 hold the outbound read pointer and bits 43:40 the inbound read pointer; each read pointer starts at 0 and wraps after 15. Bits 63:57 and 39:32 read 0.
- R7: The pending register at 0x4C keeps one bit per condition: bit 0 = outbound empty, bit 1 = outbound not empty, bit 2 = inbound empty, bit 3 = inbound not empty. A condition true in one cycle sets its bit in the next cycle. The bit stays set after the condition goes away.
- R8: Writing 1 to a bit of 0x4C clears that pending bit at that clock edge. If the condition is still true, the bit sets again one cycle later.
- R9: The enable register at 0x48 reads back bits 3:0 as written, and `irq_lines` equals pending AND enable bit by bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle; pops when it addresses receive word 1 |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Combinational read data, valid while bus_rd is high |
| irq_lines | output | 4 | Level interrupts, pending AND enable, with the bit order of R7 |

## Verification
The bench fills the outbound queue to 16 entries and pushes once more. A design that overwrote the head or let the write pointer run past the read pointer would return wrong data or a wrong count on drain. It reads receive registers on an empty queue, where a design that popped anyway would shift the read-pointer field. It acknowledges a pending bit whose condition is still true and samples the following two cycles. A design that ignored the acknowledge would never show the one-cycle drop, and one without the re-latch would leave the bit clear. It also acknowledges a bit whose condition has ended and checks that the bit stays clear. Finally, it checks that a condition that lasted only briefly still leaves its bit set; a design with plain level outputs would lose it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int W0_W = 64;
    localparam int W1_W = 32;

    typedef struct packed {
        logic [W0_W-1:0] w0;
        logic [W1_W-1:0] w1;
    } mbox_msg_t;

    // Offsets from a direction's control register.
    localparam logic [7:0] OFF_SEND0 = 8'h10;
    localparam logic [7:0] OFF_SEND1 = 8'h18;
    localparam logic [7:0] OFF_RECV0 = 8'h20;
    localparam logic [7:0] OFF_RECV1 = 8'h28;

    localparam logic [7:0] ADR_IRQ_EN  = 8'h48;
    localparam logic [7:0] ADR_IRQ_ACK = 8'h4C;

    localparam int CTL_FULL_BIT  = 16;
    localparam int CTL_EMPTY_BIT = 17;
    localparam int CTL_OVF_BIT   = 18;

    localparam int NUM_DIR = 2;   // 0 = outbound, 1 = inbound
    localparam int NUM_IRQ = 4;

    function automatic logic [7:0] dir_ctl_addr(input int dir);
        return (dir == 0) ? 8'h50 : 8'h80;
    endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo
    import mbox_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  mbox_msg_t        push_msg_i,
    input  logic             pop_i,
    input  logic             ovf_clr_i,
    output mbox_msg_t        head_o,
    output logic [CNT_W-1:0] count_o,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             ovf_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             ovf;
    } fifo_st_t;

    fifo_st_t  st_d, st_q;
    mbox_msg_t mem_q [DEPTH];
    logic      do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push_i && (st_q.count != CNT_W'(DEPTH));
        do_pop  = pop_i && (st_q.count != '0);
        if (do_push) st_d.wr_ptr = ptr_next(st_q.wr_ptr);
        if (do_pop)  st_d.rd_ptr = ptr_next(st_q.rd_ptr);
        if (do_push && !do_pop)      st_d.count = st_q.count + 1'b1;
        else if (!do_push && do_pop) st_d.count = st_q.count - 1'b1;
        if (ovf_clr_i) st_d.ovf = 1'b0;
        if (push_i && !do_push) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr_ptr] <= push_msg_i;
    end

    assign head_o   = mem_q[st_q.rd_ptr];
    assign count_o  = st_q.count;
    assign rd_ptr_o = st_q.rd_ptr;
    assign full_o   = (st_q.count == CNT_W'(DEPTH));
    assign empty_o  = (st_q.count == '0);
    assign ovf_o    = st_q.ovf;

    AST_PUSH_FULL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && full_o && !pop_i |=> $stable(count_o) && ovf_o); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o && !ovf_clr_i |=> ovf_o); // R4
    AST_POP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && empty_o && !push_i |=> $stable(rd_ptr_o) && empty_o); // R5

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond_i,
    input  logic [N-1:0] ack_i,
    input  logic         en_wr_i,
    input  logic [N-1:0] en_wdata_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] en_o,
    output logic [N-1:0] irq_o
);

    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] en;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend | cond_i) & ~ack_i;
        if (en_wr_i) st_d.en = en_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;
    assign irq_o  = st_q.pend & st_q.en;

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i != '0) |=> ((pend_o & $past(ack_i)) == '0)); // R8
    AST_COND_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i & ~ack_i) != '0 |=> ((~pend_o & $past(cond_i & ~ack_i)) == '0)); // R7
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o & ~ack_i) != '0 |=> ((~pend_o & $past(pend_o & ~ack_i)) == '0)); // R7

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    output logic [3:0]        irq_lines
);

    typedef struct packed {
        logic [NUM_DIR-1:0][W0_W-1:0] stage;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_DIR-1:0] hit_ctl, hit_s0, hit_s1, hit_r0, hit_r1;
    logic [NUM_DIR-1:0] push, pop, ovf_clr, full, empty, ovf;
    mbox_msg_t          push_msg [NUM_DIR];
    mbox_msg_t          head     [NUM_DIR];
    logic [CNT_W-1:0]   cnt      [NUM_DIR];
    logic [PTR_W-1:0]   rptr     [NUM_DIR];

    logic                hit_en, hit_ack;
    logic [NUM_IRQ-1:0]  irq_cond, irq_ack, pend, en;
    logic [63:0]         status_word;

    assign hit_en  = (bus_addr == ADDR_W'(ADR_IRQ_EN));
    assign hit_ack = (bus_addr == ADDR_W'(ADR_IRQ_ACK));

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        assign hit_ctl[d] = (bus_addr == ADDR_W'(dir_ctl_addr(d)));
        assign hit_s0[d]  = (bus_addr == ADDR_W'(dir_ctl_addr(d) + OFF_SEND0));
        assign hit_s1[d]  = (bus_addr == ADDR_W'(dir_ctl_addr(d) + OFF_SEND1));
        assign hit_r0[d]  = (bus_addr == ADDR_W'(dir_ctl_addr(d) + OFF_RECV0));
        assign hit_r1[d]  = (bus_addr == ADDR_W'(dir_ctl_addr(d) + OFF_RECV1));

        assign push[d]     = bus_wr && hit_s1[d];
        assign pop[d]      = bus_rd && hit_r1[d];
        assign ovf_clr[d]  = bus_wr && hit_ctl[d] && bus_wdata[CTL_OVF_BIT];
        assign push_msg[d] = '{w0: st_q.stage[d], w1: bus_wdata[W1_W-1:0]};

        mbox_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_i     (push[d]),
            .push_msg_i (push_msg[d]),
            .pop_i      (pop[d]),
            .ovf_clr_i  (ovf_clr[d]),
            .head_o     (head[d]),
            .count_o    (cnt[d]),
            .rd_ptr_o   (rptr[d]),
            .full_o     (full[d]),
            .empty_o    (empty[d]),
            .ovf_o      (ovf[d])
        );
    end

    // Staging registers for the first data word of each direction.
    always_comb begin
        st_d = st_q;
        for (int d = 0; d < NUM_DIR; d++) begin
            if (bus_wr && hit_s0[d]) st_d.stage[d] = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Condition order: out empty, out not empty, in empty, in not empty.
    assign irq_cond = {~empty[1], empty[1], ~empty[0], empty[0]};
    assign irq_ack  = (bus_wr && hit_ack) ? bus_wdata[NUM_IRQ-1:0] : '0;

    mbox_irq #(.N(NUM_IRQ)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cond_i     (irq_cond),
        .ack_i      (irq_ack),
        .en_wr_i    (bus_wr && hit_en),
        .en_wdata_i (bus_wdata[NUM_IRQ-1:0]),
        .pend_o     (pend),
        .en_o       (en),
        .irq_o      (irq_lines)
    );

    always_comb begin
        status_word        = '0;
        status_word[56:52] = 5'(cnt[0]);
        status_word[51:48] = 4'(cnt[1]);
        status_word[47:44] = 4'(rptr[0]);
        status_word[43:40] = 4'(rptr[1]);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_en)  bus_rdata[NUM_IRQ-1:0] = en;
            if (hit_ack) bus_rdata[NUM_IRQ-1:0] = pend;
            for (int d = 0; d < NUM_DIR; d++) begin
                if (hit_ctl[d]) begin
                    bus_rdata[CTL_FULL_BIT]  = full[d];
                    bus_rdata[CTL_EMPTY_BIT] = empty[d];
                    bus_rdata[CTL_OVF_BIT]   = ovf[d];
                end
                if (hit_r0[d] && !empty[d]) bus_rdata = head[d].w0;
                if (hit_r1[d]) begin
                    bus_rdata = status_word;
                    if (!empty[d]) bus_rdata[W1_W-1:0] = head[d].w1;
                end
            end
        end
    end

    AST_STAGE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && hit_s0[0] && !bus_rd |=> $stable(cnt[0])); // R2
    AST_RECV0_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && hit_r0[1] && !bus_wr |=> $stable(cnt[1])); // R2
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && hit_r0[0] && empty[0] |-> bus_rdata == '0); // R5

endmodule

// File: tb/ipc_mailbox_test.sv
`timescale 1ns/1ps
module ipc_mailbox_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [3:0]  irq_lines;

    int total = 0;
    int fails = 0;

    logic [95:0] q_out [$];
    logic [95:0] q_in  [$];
    int rp_out = 0;
    int rp_in  = 0;

    always #2.5 clk = ~clk;

    ipc_mailbox uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lines(irq_lines)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [63:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [63:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        #1;
    endtask

    function automatic logic [11:0] ctl(input int d);
        return (d == 0) ? 12'h050 : 12'h080;
    endfunction

    function automatic logic [63:0] exp_status();
        logic [63:0] s = '0;
        s[56:52] = 5'(q_out.size());
        s[51:48] = 4'(q_in.size());
        s[47:44] = 4'(rp_out);
        s[43:40] = 4'(rp_in);
        return s;
    endfunction

    task automatic send(input int d, input logic [63:0] w0, input logic [31:0] w1);
        bus_write(ctl(d) + 12'h10, w0);
        bus_write(ctl(d) + 12'h18, {32'hA5A5_5A5A, w1});
        if (d == 0) begin if (q_out.size() < 16) q_out.push_back({w0, w1}); end
        else        begin if (q_in.size()  < 16) q_in.push_back({w0, w1}); end
    endtask

    task automatic recv_chk(input int d);
        logic [63:0] r;
        logic [95:0] m;
        logic        emp;
        emp = (d == 0) ? (q_out.size() == 0) : (q_in.size() == 0);
        m   = emp ? '0 : ((d == 0) ? q_out[0] : q_in[0]);
        bus_read(ctl(d) + 12'h20, r);
        chk(emp ? "R5 empty recv word0" : "R2 recv word0", r, m[95:32]);
        bus_read(ctl(d) + 12'h28, r);
        chk(emp ? "R5 empty recv word1" : "R2 R6 recv word1", r, exp_status() | {32'h0, m[31:0]});
        if (!emp) begin
            if (d == 0) begin void'(q_out.pop_front()); rp_out = (rp_out + 1) % 16; end
            else        begin void'(q_in.pop_front());  rp_in  = (rp_in + 1) % 16; end
        end
    endtask

    task automatic t_reset();
        logic [63:0] r;
        settle();
        bus_read(ctl(0), r); chk("R1 outbound control", r, 64'h2_0000);
        bus_read(ctl(1), r); chk("R1 inbound control", r, 64'h2_0000);
        bus_read(12'h048, r); chk("R1 enable reg", r, 64'h0);
        chk("R1 irq lines", {60'h0, irq_lines}, 64'h0);
        bus_read(12'h04C, r); chk("R7 pending after reset", r, 64'h5);
    endtask

    task automatic t_roundtrip();
        for (int i = 0; i < 3; i++) begin
            send(0, 64'h1111_0000_0000_0000 + 64'(i), 32'hC000_0000 + 32'(i));
            send(1, 64'h2222_0000_0000_0000 + 64'(i), 32'hD000_0000 + 32'(i));
        end
        recv_chk(1);
        for (int i = 0; i < 3; i++) recv_chk(0);
        recv_chk(1); recv_chk(1);
        recv_chk(1);   // inbound empty: R5, pointer field must not move
        recv_chk(0);   // outbound empty: R5
    endtask

    task automatic t_fill();
        logic [63:0] r;
        for (int i = 0; i < 16; i++) send(0, 64'hF00D_0000_0000_0000 + 64'(i), 32'(i * 7));
        bus_read(ctl(0), r); chk("R3 full flag at 16", r, 64'h1_0000);
        send(0, 64'hBAD0_BAD0_BAD0_BAD0, 32'hBAD0_0000);
        bus_read(ctl(0), r); chk("R4 overflow after drop", r, 64'h5_0000);
        recv_chk(1);   // inbound empty: status reports outbound count 16 (R6)
        bus_write(ctl(0), 64'h4_0000);
        bus_read(ctl(0), r); chk("R4 overflow cleared", r, 64'h1_0000);
        for (int i = 0; i < 16; i++) recv_chk(0);
        bus_read(ctl(0), r); chk("R3 empty after drain", r, 64'h2_0000);
        recv_chk(0);
    endtask

    task automatic t_irq();
        logic [63:0] r;
        bus_write(12'h048, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_read(12'h048, r); chk("R9 enable readback", r, 64'hF);
        bus_write(12'h04C, 64'hF);   // start from a known pending state
        settle();
        chk("R9 irq lines both empty", {60'h0, irq_lines}, 64'h5);
        send(1, 64'h3333, 32'h4444);
        settle();
        bus_read(12'h04C, r); chk("R7 inbound empty stays latched", r, 64'hD);
        bus_write(12'h04C, 64'h4);
        settle();
        bus_read(12'h04C, r); chk("R8 ack of ended condition", r, 64'h9);
        recv_chk(1);
        settle();
        bus_read(12'h04C, r); chk("R7 not-empty stays latched", r, 64'hD);
        bus_write(12'h04C, 64'h8);
        settle();
        bus_read(12'h04C, r); chk("R8 ack bit3", r, 64'h5);
        bus_write(12'h04C, 64'h1);
        bus_read(12'h04C, r); chk("R8 cleared one cycle", r, 64'h4);
        bus_read(12'h04C, r); chk("R8 re-latched", r, 64'h5);
        bus_write(12'h048, 64'h8);
        send(1, 64'h5555, 32'h6666);
        settle();
        chk("R9 irq gated by enable", {60'h0, irq_lines}, 64'h8);
        recv_chk(1);
    endtask

    initial begin
        #1_000_000;
        fails++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_roundtrip();
        t_fill();
        t_irq();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule